// File: doc/BRIEF.md
# Configurable Serial Transmitter with Flow Control

This block serialises words onto a single asynchronous line. The line rests high. Each frame starts with a low start bit. The data bits follow, least significant bit first, then an optional parity bit, then one or two high stop bits. Every bit lasts `BAUD_DIV` system clocks. The frame format is taken from the configuration inputs at the moment a word is accepted, so each frame can use a different format. A word is accepted when `inValid` and `inReady` are both high on a clock edge.

Two kinds of flow control decide when a new frame may begin. The hardware clear-to-send input is looked at only while the transmitter is between frames. When software flow control is enabled, characters from a neighbouring receiver can pause or resume the transmitter: 0x13 pauses it and 0x11 resumes it. A frame that has already started is always sent to the end, whatever happens to either control.

Top module: `uart_tx_flow`

## Requirements
- R1: After reset, `txLine` is high. Between frames the line stays high. With `ctsOk` high and no pause in force, `inReady` is high.
- R2: A frame starts one clock after the accepting edge. It is a low start bit, the data bits LSB first, the parity bit if enabled, then the stop bits. Each bit holds for exactly `BAUD_DIV` clocks.
- R3: `cfgDataBits` selects 5, 6, 7, 8 or 9 data bits. A request below 5 is treated as 5, and a request above 9 is treated as 9. Bits of `inData` above the selected length are not sent.
- R4: `cfgParity` encodes the parity mode: 0 none, 1 even, 2 odd, 3 mark (always 1), 4 space (always 0). Codes 5 to 7 mean none. Even parity makes the number of ones in the data bits plus the parity bit even. Odd parity makes that number odd.
- R5: `cfgTwoStop` = 0 sends one stop bit and 1 sends two. `inReady` rises again in the first clock after the last stop bit ends.
- R6: A request for 9 data bits with even or odd parity is sent with mark parity. While that request is present, `cfgError` is high; otherwise it is low.
- R7: `inReady` is high only between frames and only while `ctsOk` is high. A change of `ctsOk` during a frame neither shortens nor alters that frame.
- R8: With `swFlowEn` high, a character 0x13 marked by `rxCharValid` holds `inReady` low from the next clock on. It stays low until a character 0x11 arrives. A frame already in progress completes unchanged.
- R9: With `swFlowEn` low, received characters have no effect on `inReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset, synchronous |
| cfgDataBits | input | 4 | Requested number of data bits |
| cfgParity | input | 3 | Parity mode code |
| cfgTwoStop | input | 1 | High selects two stop bits |
| inData | input | 9 | Word to transmit, bit 0 sent first |
| inValid | input | 1 | Word on `inData` is offered |
| inReady | output | 1 | Transmitter will accept a word on this edge |
| ctsOk | input | 1 | Peer is clear to receive, active high |
| swFlowEn | input | 1 | Enables pause/resume by received characters |
| rxChar | input | 8 | Character from the companion receiver |
| rxCharValid | input | 1 | `rxChar` holds a new character this clock |
| txLine | output | 1 | Serial output line |
| cfgError | output | 1 | Invalid 9-bit parity request was substituted |

## Verification
The main function is exercised with a set of words that covers every data length from 5 to 9. Each parity mode is used, and both stop settings appear. Alternating, all-ones, all-zero and single-bit data patterns separate LSB-first order from MSB-first order and expose a parity bit of the wrong sense. Masked upper bits and a clamped length request show whether the length control truncates the word properly. Dropping `ctsOk` or sending 0x13 in the middle of a frame separates gating at the frame boundary from gating at each bit. Received characters with `swFlowEn` low show that the software path is truly disabled.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int MAX_BITS = 9;
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } parity_e;

  // Normalised frame format, captured at acceptance.
  typedef struct packed {
    logic [3:0] nBits;
    logic [2:0] par;
    logic       twoStop;
    logic       err;
  } frame_fmt_t;

  // Strobes from control to datapath, one per bit boundary.
  typedef struct packed {
    logic load;
    logic emitStart;
    logic emitData;
    logic emitParity;
    logic emitStop;
  } tx_strobe_t;

  function automatic frame_fmt_t normaliseFmt(input logic [3:0] bitsReq,
                                              input logic [2:0] parReq,
                                              input logic       twoReq);
    frame_fmt_t f;
    f.twoStop = twoReq;
    f.err     = 1'b0;
    if (bitsReq < 4'(MIN_BITS))      f.nBits = 4'(MIN_BITS);
    else if (bitsReq > 4'(MAX_BITS)) f.nBits = 4'(MAX_BITS);
    else                             f.nBits = bitsReq;
    f.par = (parReq > PAR_SPACE) ? PAR_NONE : parReq;
    if (f.nBits == 4'(MAX_BITS) && (f.par == PAR_EVEN || f.par == PAR_ODD)) begin
      f.par = PAR_MARK;
      f.err = 1'b1;
    end
    return f;
  endfunction

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int BAUD_DIV = 16,
  parameter logic [7:0] XON_CODE = 8'h11,
  parameter logic [7:0] XOFF_CODE = 8'h13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       ctsOk,
  input  logic       swFlowEn,
  input  logic [7:0] rxChar,
  input  logic       rxCharValid,
  input  frame_fmt_t fmtReq,
  output logic       inReady,
  output tx_strobe_t strobe
);

  localparam int CNT_W = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BAUD_DIV - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} tx_state_e;

  tx_state_e        state, stateNext;
  logic [CNT_W-1:0] baudCnt;
  logic [3:0]       bitCnt, bitNext;
  frame_fmt_t       fmtQ;
  logic             pausedQ;
  logic             bitEnd;
  logic             accept;

  assign bitEnd  = (baudCnt == CNT_LAST);
  assign inReady = (state == ST_IDLE) && ctsOk && !(swFlowEn && pausedQ);
  assign accept  = inValid && inReady;

  always_comb begin
    stateNext = state;
    bitNext   = bitCnt;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        strobe.load      = 1'b1;
        strobe.emitStart = 1'b1;
        stateNext        = ST_START;
      end
      ST_START: if (bitEnd) begin
        strobe.emitData = 1'b1;
        bitNext         = '0;
        stateNext       = ST_DATA;
      end
      ST_DATA: if (bitEnd) begin
        if (bitCnt == 4'(fmtQ.nBits - 4'd1)) begin
          if (fmtQ.par != PAR_NONE) begin
            strobe.emitParity = 1'b1;
            stateNext         = ST_PAR;
          end else begin
            strobe.emitStop = 1'b1;
            bitNext         = '0;
            stateNext       = ST_STOP;
          end
        end else begin
          strobe.emitData = 1'b1;
          bitNext         = bitCnt + 4'd1;
        end
      end
      ST_PAR: if (bitEnd) begin
        strobe.emitStop = 1'b1;
        bitNext         = '0;
        stateNext       = ST_STOP;
      end
      ST_STOP: if (bitEnd) begin
        if (fmtQ.twoStop && bitCnt == 4'd0) bitNext = 4'd1;
        else                                stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      baudCnt <= '0;
      bitCnt  <= '0;
      fmtQ    <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitNext;
      if (state == ST_IDLE || bitEnd) baudCnt <= '0;
      else                            baudCnt <= baudCnt + 1'b1;
      if (accept) fmtQ <= fmtReq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !swFlowEn) pausedQ <= 1'b0;
    else if (rxCharValid) begin
      if (rxChar == XOFF_CODE)     pausedQ <= 1'b1;
      else if (rxChar == XON_CODE) pausedQ <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_dp.sv
module uart_tx_dp
  import uart_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  tx_strobe_t          strobe,
  input  logic [MAX_BITS-1:0] inData,
  input  frame_fmt_t          fmtReq,
  output logic                txLine
);

  logic [MAX_BITS-1:0] masked;
  logic [MAX_BITS-1:0] shiftQ;
  logic                parQ;
  logic                parBit;
  logic                lineQ;

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign masked[i] = inData[i] && (fmtReq.nBits > 4'(i));
  end

  always_comb begin
    unique case (fmtReq.par)
      PAR_EVEN: parBit = ^masked;
      PAR_ODD:  parBit = ~^masked;
      PAR_MARK: parBit = 1'b1;
      default:  parBit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
      parQ   <= 1'b0;
      lineQ  <= 1'b1;
    end else begin
      if (strobe.load) begin
        shiftQ <= masked;
        parQ   <= parBit;
      end
      if (strobe.emitStart) lineQ <= 1'b0;
      else if (strobe.emitData) begin
        lineQ  <= shiftQ[0];
        shiftQ <= shiftQ >> 1;
      end
      else if (strobe.emitParity) lineQ <= parQ;
      else if (strobe.emitStop)   lineQ <= 1'b1;
    end
  end

  assign txLine = lineQ;

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_pkg::*;
#(
  parameter int BAUD_DIV = 16,
  parameter logic [7:0] XON_CODE = 8'h11,
  parameter logic [7:0] XOFF_CODE = 8'h13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] cfgDataBits,
  input  logic [2:0] cfgParity,
  input  logic       cfgTwoStop,
  input  logic [8:0] inData,
  input  logic       inValid,
  output logic       inReady,
  input  logic       ctsOk,
  input  logic       swFlowEn,
  input  logic [7:0] rxChar,
  input  logic       rxCharValid,
  output logic       txLine,
  output logic       cfgError
);

  frame_fmt_t fmtReq;
  tx_strobe_t strobe;

  assign fmtReq   = normaliseFmt(cfgDataBits, cfgParity, cfgTwoStop);
  assign cfgError = fmtReq.err;

  uart_tx_ctrl #(
    .BAUD_DIV (BAUD_DIV),
    .XON_CODE (XON_CODE),
    .XOFF_CODE(XOFF_CODE)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .ctsOk      (ctsOk),
    .swFlowEn   (swFlowEn),
    .rxChar     (rxChar),
    .rxCharValid(rxCharValid),
    .fmtReq     (fmtReq),
    .inReady    (inReady),
    .strobe     (strobe)
  );

  uart_tx_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .inData(inData),
    .fmtReq(fmtReq),
    .txLine(txLine)
  );

endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk #(
  parameter logic [7:0] XOFF_CODE = 8'h13
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       ctsOk,
  input logic       swFlowEn,
  input logic [7:0] rxChar,
  input logic       rxCharValid,
  input logic       txLine
);

  // R1: line rests high whenever a word could be accepted
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> txLine);

  // R2: the accepting edge is followed by the start bit
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !txLine);

  // R7: ready never offered without clear-to-send
  assert_cts_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> ctsOk);

  // R7: after acceptance the block is busy in the next cycle
  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);

  // R8: pause character blocks new frames from the next cycle
  assert_pause_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    (swFlowEn && rxCharValid && rxChar == XOFF_CODE) |=> (!inReady || !swFlowEn));

endmodule

bind uart_tx_flow uart_tx_flow_chk #(.XOFF_CODE(XOFF_CODE)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .ctsOk      (ctsOk),
  .swFlowEn   (swFlowEn),
  .rxChar     (rxChar),
  .rxCharValid(rxCharValid),
  .txLine     (txLine)
);

// File: tb/uart_tx_flow_tb.sv
module uart_tx_flow_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BAUD = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cfgDataBits = 4'd8;
  logic [2:0] cfgParity = 3'd0;
  logic       cfgTwoStop = 1'b0;
  logic [8:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       ctsOk = 1'b1;
  logic       swFlowEn = 1'b0;
  logic [7:0] rxChar = '0;
  logic       rxCharValid = 1'b0;
  logic       txLine;
  logic       cfgError;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tx_flow #(.BAUD_DIV(BAUD)) u_dut (
    .clk(clk), .rstN(rstN), .cfgDataBits(cfgDataBits), .cfgParity(cfgParity),
    .cfgTwoStop(cfgTwoStop), .inData(inData), .inValid(inValid), .inReady(inReady),
    .ctsOk(ctsOk), .swFlowEn(swFlowEn), .rxChar(rxChar), .rxCharValid(rxCharValid),
    .txLine(txLine), .cfgError(cfgError)
  );

  typedef struct packed {
    logic [8:0] data;
    logic [3:0] nBits;
    logic [2:0] par;
    logic       two;
    logic       expErr;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{9'h055, 4'd8, 3'd0, 1'b0, 1'b0},
    '{9'h0A3, 4'd5, 3'd1, 1'b0, 1'b0},
    '{9'h03C, 4'd6, 3'd2, 1'b1, 1'b0},
    '{9'h07F, 4'd7, 3'd3, 1'b0, 1'b0},
    '{9'h081, 4'd8, 3'd4, 1'b1, 1'b0},
    '{9'h1A5, 4'd9, 3'd3, 1'b0, 1'b0},
    '{9'h15A, 4'd9, 3'd4, 1'b1, 1'b0},
    '{9'h0F0, 4'd9, 3'd1, 1'b0, 1'b1},
    '{9'h000, 4'd8, 3'd2, 1'b0, 1'b0},
    '{9'h1FF, 4'd3, 3'd0, 1'b0, 1'b0},
    '{9'h096, 4'd8, 3'd1, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] got,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finishRun();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Expected line sequence, independent of the design.
  function automatic int buildExp(input logic [8:0] d, input int nb, input int par,
                                  input bit two, output logic [15:0] seq);
    int nbE, parE, idx, ones;
    seq = '1;
    nbE = (nb < 5) ? 5 : ((nb > 9) ? 9 : nb);
    parE = (par > 4) ? 0 : par;
    if (nbE == 9 && (parE == 1 || parE == 2)) parE = 3;
    seq[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nbE; i++) begin
      seq[1+i] = d[i];
      ones += d[i];
    end
    idx = 1 + nbE;
    if (parE != 0) begin
      case (parE)
        1: seq[idx] = ones[0];
        2: seq[idx] = ~ones[0];
        3: seq[idx] = 1'b1;
        default: seq[idx] = 1'b0;
      endcase
      idx++;
    end
    seq[idx] = 1'b1; idx++;
    if (two) begin seq[idx] = 1'b1; idx++; end
    return idx;
  endfunction

  // midAct: 0 none, 1 drop ctsOk after acceptance, 2 send pause char after acceptance
  task automatic runFrame(input logic [8:0] d, input logic [3:0] nb, input logic [2:0] par,
                          input bit two, input int midAct, input string req);
    logic [15:0] expSeq, gotSeq;
    int total;
    bit readyBad;
    total = buildExp(d, int'(nb), int'(par), two, expSeq);
    gotSeq = '1;
    readyBad = 0;
    @(negedge clk);
    cfgDataBits = nb; cfgParity = par; cfgTwoStop = two;
    inData = d; inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    inData = ~d;
    cfgDataBits = 4'd6; cfgParity = 3'd2; cfgTwoStop = ~two;
    if (midAct == 1) ctsOk = 1'b0;
    if (midAct == 2) begin rxChar = 8'h13; rxCharValid = 1'b1; end
    @(negedge clk);
    rxCharValid = 1'b0;
    repeat (BAUD/2 - 1) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      gotSeq[i] = txLine;
      if (inReady) readyBad = 1;
      repeat (BAUD) @(negedge clk);
    end
    check(gotSeq == expSeq, req, gotSeq, expSeq);
    check(!readyBad && (inReady == (midAct == 0)), "R5 ready after last stop",
          {15'd0, inReady}, {15'd0, 1'(midAct == 0)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(txLine == 1'b1, "R1 line during reset", {15'd0, txLine}, 16'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(txLine == 1'b1 && inReady == 1'b1, "R1 idle after reset",
          {14'd0, txLine, inReady}, 16'd3);

    // Table of frame formats: R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      cfgDataBits = VECS[v].nBits; cfgParity = VECS[v].par; cfgTwoStop = VECS[v].two;
      #1;
      check(cfgError == VECS[v].expErr, "R6 error flag", {15'd0, cfgError},
            {15'd0, VECS[v].expErr});
      runFrame(VECS[v].data, VECS[v].nBits, VECS[v].par, VECS[v].two, 0,
               "R2 R3 R4 frame content");
    end

    // R7: no clear-to-send, nothing starts
    @(negedge clk);
    ctsOk = 1'b0; inData = 9'h0AA; inValid = 1'b1;
    cfgDataBits = 4'd8; cfgParity = 3'd0; cfgTwoStop = 1'b0;
    begin
      bit moved = 0;
      for (int i = 0; i < 3*BAUD; i++) begin
        @(negedge clk);
        if (!txLine || inReady) moved = 1;
      end
      check(!moved, "R7 blocked by ctsOk", {15'd0, moved}, 16'd0);
    end
    inValid = 1'b0;
    ctsOk = 1'b1;

    // R7: ctsOk drops mid-frame, frame unchanged
    runFrame(9'h0C5, 4'd8, 3'd1, 1'b0, 1, "R7 cts drop mid-frame");
    ctsOk = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R7 ready on cts return", {15'd0, inReady}, 16'd1);

    // R8: pause mid-frame, frame completes, then held
    swFlowEn = 1'b1;
    runFrame(9'h033, 4'd7, 3'd2, 1'b1, 2, "R8 pause mid-frame");
    inValid = 1'b1; inData = 9'h011;
    begin
      bit moved = 0;
      for (int i = 0; i < 3*BAUD; i++) begin
        @(negedge clk);
        if (!txLine || inReady) moved = 1;
      end
      check(!moved, "R8 paused holds line", {15'd0, moved}, 16'd0);
    end
    inValid = 1'b0;
    rxChar = 8'h11; rxCharValid = 1'b1;
    @(negedge clk);
    rxCharValid = 1'b0;
    check(inReady == 1'b1, "R8 resume character", {15'd0, inReady}, 16'd1);

    // R9: characters ignored with software flow off
    swFlowEn = 1'b0;
    rxChar = 8'h13; rxCharValid = 1'b1;
    @(negedge clk);
    rxCharValid = 1'b0;
    @(negedge clk);
    check(inReady == 1'b1, "R9 pause char ignored", {15'd0, inReady}, 16'd1);
    runFrame(9'h13C, 4'd9, 3'd4, 1'b0, 0, "R9 frame after ignored char");

    finishRun();
  end

endmodule